// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Timing

This block is a single-slave SPI master in mode 0 whose serial-clock shape and chip-select sequencing are set by cycle counts. The counts are in controller clock cycles. The SCK high phase and the SCK low phase are set on their own. The SCK fields are stored as count minus one. The chip-select setup, hold and idle delays are given as plain cycle counts, and a count of zero selects a default of one full SCK period. That default is the high count plus the low count.

A host presents a word together with the timing fields on a valid/ready handshake. The block samples the timing fields only in the cycle it accepts the word. It then asserts the active-low chip select and waits out the setup delay. It clocks `DATA_W` bits MSB first, waits out the hold delay and releases chip select. In that same cycle it pulses `rx_done` with the received word on `rx_data`. It does not accept the next word until chip select has stayed high for the idle count. With both SCK fields at zero, SCK runs at half the controller clock, which is the fastest rate the block supports.

The parameter `WIDE_TIMING` sets the width of the SCK, setup and hold fields: 16 bits when it is 1, 8 bits when it is 0. The idle field is 8 bits in both cases.

Top module: `spi_cs_timed_master`

## Requirements
- R1: Each SCK high phase lasts `cfg_sck_hi_m1`+1 clock cycles. Each SCK low phase between two bits lasts `cfg_sck_lo_m1`+1 cycles.
- R2: With both SCK fields at 0, SCK alternates every cycle, giving a period of 2 clock cycles (half the controller clock).
- R3: The first SCK rising edge follows the falling edge of `spi_cs_n` by `cfg_setup_cyc` cycles. When that field is 0, the delay is (`cfg_sck_hi_m1`+1)+(`cfg_sck_lo_m1`+1) cycles.
- R4: `spi_cs_n` rises `cfg_hold_cyc` cycles after the last SCK falling edge. When that field is 0, the same full-period default as in R3 applies.
- R5: After `spi_cs_n` rises it stays high for at least `cfg_idle_cyc` cycles, and exactly that many when a word is already waiting. A zero field uses the full-period default. `in_ready` is low whenever `spi_cs_n` is low and during the idle wait.
- R6: Mode 0 applies. SCK is low whenever `spi_cs_n` is high. `spi_mosi` carries `in_data` MSB first, is valid at each rising edge, and does not change while SCK is high. `spi_miso` is sampled at the rising edges, MSB first.
- R7: `rx_done` is high for exactly one cycle, in the first cycle that `spi_cs_n` is high again. In that cycle `rx_data` holds the received word.
- R8: The timing fields are captured when a word is accepted. Changes to them during a transfer do not affect that transfer.
- R9: With `WIDE_TIMING`=1, field values above 255 take effect in full. For example, `cfg_sck_hi_m1`=300 gives a 301-cycle high phase.
- R10: After reset, `spi_cs_n`=1, `spi_sck`=0, `rx_done`=0 and `in_ready`=1.
- R11: Each transfer has exactly `DATA_W` SCK rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sck_hi_m1 | input | TW | SCK high phase, in cycles minus one |
| cfg_sck_lo_m1 | input | TW | SCK low phase, in cycles minus one |
| cfg_setup_cyc | input | TW | Cycles from CS low to the first rising edge; 0 selects the default |
| cfg_hold_cyc | input | TW | Cycles from the last falling edge to CS high; 0 selects the default |
| cfg_idle_cyc | input | 8 | Minimum cycles CS stays high between transfers; 0 selects the default |
| in_valid | input | 1 | Word to send is present |
| in_ready | output | 1 | Block accepts a word this cycle |
| in_data | input | DATA_W | Word to send |
| rx_data | output | DATA_W | Last received word |
| rx_done | output | 1 | One-cycle pulse when a transfer ends |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Chip select, active low |

## Verification
A phase counter that is loaded with the wrong field, or off by one, shows at the SCK and CS pins within one phase. The lengths of the high run, the low run, the setup run and the hold run each differ from the computed count at the next edge. A bit counter that is wrong shows at the release sample as a rising-edge count other than `DATA_W`, and it also shifts the received and sent words. A fault in the idle wait or in the ready logic shows in the very next gap: either a CS-high run of the wrong length, or `in_ready` high while CS is low. Capture of the fields is exposed because the host changes them right after every accept.

// File: rtl/spi_ct_pkg.sv
package spi_ct_pkg;

  // Internal delay width: holds hi+lo+2 for 16-bit fields without overflow.
  localparam int DLY_W = 18;
  typedef logic [DLY_W-1:0] dly_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } seq_t;

  // One full SCK period in controller cycles, from the two minus-one fields.
  function automatic dly_t full_period(dly_t hi_m1, dly_t lo_m1);
    return hi_m1 + lo_m1 + dly_t'(2);
  endfunction

  // Converts a requested delay (0 selects the default) into a minus-one counter load.
  function automatic dly_t delay_m1(dly_t req, dly_t period);
    return (req == '0) ? (period - dly_t'(1)) : (req - dly_t'(1));
  endfunction

endpackage

// File: rtl/spi_ct_cfg.sv
module spi_ct_cfg
  import spi_ct_pkg::*;
#(
  parameter int TW     = 16,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TW-1:0]     sck_hi_m1,
  input  logic [TW-1:0]     sck_lo_m1,
  input  logic [TW-1:0]     setup_cyc,
  input  logic [TW-1:0]     hold_cyc,
  input  logic [IDLE_W-1:0] idle_cyc,
  output dly_t              setup_m1_now,
  output dly_t              hi_m1_q,
  output dly_t              lo_m1_q,
  output dly_t              hold_m1_q,
  output dly_t              idle_m1_q
);

  dly_t hi_ext, lo_ext, period_now;

  assign hi_ext       = dly_t'(sck_hi_m1);
  assign lo_ext       = dly_t'(sck_lo_m1);
  assign period_now   = full_period(hi_ext, lo_ext);
  assign setup_m1_now = delay_m1(dly_t'(setup_cyc), period_now);

  // Fields are captured only at accept; later input changes wait for the next word.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_m1_q   <= '0;
      lo_m1_q   <= '0;
      hold_m1_q <= '0;
      idle_m1_q <= '0;
    end else if (load) begin
      hi_m1_q   <= hi_ext;
      lo_m1_q   <= lo_ext;
      hold_m1_q <= delay_m1(dly_t'(hold_cyc), period_now);
      idle_m1_q <= delay_m1(dly_t'(idle_cyc), period_now);
    end
  end

endmodule

// File: rtl/spi_ct_seq.sv
module spi_ct_seq
  import spi_ct_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  dly_t setup_m1_now,
  input  dly_t hi_m1,
  input  dly_t lo_m1,
  input  dly_t hold_m1,
  input  dly_t idle_m1,
  output logic ready,
  output logic cs_n,
  output logic sck,
  output logic ev_rise,
  output logic ev_fall,
  output logic ev_release
);

  localparam int BCW = $clog2(DATA_W + 1);

  seq_t           st;
  dly_t           cnt;
  logic [BCW-1:0] nrise;
  logic           cnt_zero, last_bit, ev_last_fall, ev_gap_end;

  assign cnt_zero     = (cnt == '0);
  assign last_bit     = (nrise == BCW'(DATA_W));
  assign ev_rise      = ((st == ST_SETUP) || (st == ST_LOW)) && cnt_zero;
  assign ev_fall      = (st == ST_HIGH) && cnt_zero && !last_bit;
  assign ev_last_fall = (st == ST_HIGH) && cnt_zero && last_bit;
  assign ev_release   = (st == ST_HOLD) && cnt_zero;
  assign ev_gap_end   = (st == ST_GAP) && cnt_zero;
  assign ready        = (st == ST_IDLE) || ev_gap_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      nrise <= '0;
      cs_n  <= 1'b1;
      sck   <= 1'b0;
    end else if (start) begin
      st    <= ST_SETUP;
      cnt   <= setup_m1_now;
      nrise <= '0;
      cs_n  <= 1'b0;
    end else begin
      case (st)
        ST_SETUP, ST_LOW: begin
          if (cnt_zero) begin
            st    <= ST_HIGH;
            sck   <= 1'b1;
            cnt   <= hi_m1;
            nrise <= nrise + BCW'(1);
          end else begin
            cnt <= cnt - dly_t'(1);
          end
        end
        ST_HIGH: begin
          if (ev_last_fall) begin
            st  <= ST_HOLD;
            sck <= 1'b0;
            cnt <= hold_m1;
          end else if (ev_fall) begin
            st  <= ST_LOW;
            sck <= 1'b0;
            cnt <= lo_m1;
          end else begin
            cnt <= cnt - dly_t'(1);
          end
        end
        ST_HOLD: begin
          if (cnt_zero) begin
            st   <= ST_GAP;
            cs_n <= 1'b1;
            cnt  <= idle_m1;
          end else begin
            cnt <= cnt - dly_t'(1);
          end
        end
        ST_GAP: begin
          if (cnt_zero) st <= ST_IDLE;
          else          cnt <= cnt - dly_t'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_ct_shift.sv
module spi_ct_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              ev_rise,
  input  logic              ev_fall,
  input  logic              ev_release,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_data,
  output logic              done
);

  logic [DATA_W-1:0] tx_sh, rx_sh;

  assign mosi = tx_sh[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= ev_release;
      if (load)         tx_sh <= tx_word;
      else if (ev_fall) tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
      if (ev_rise)      rx_sh <= {rx_sh[DATA_W-2:0], miso};
      if (ev_release)   rx_data <= rx_sh;
    end
  end

endmodule

// File: rtl/spi_cs_timed_master.sv
module spi_cs_timed_master
  import spi_ct_pkg::*;
#(
  parameter  int DATA_W      = 8,
  parameter  int WIDE_TIMING = 1,
  localparam int TW          = (WIDE_TIMING != 0) ? 16 : 8,
  localparam int IDLE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     cfg_sck_hi_m1,
  input  logic [TW-1:0]     cfg_sck_lo_m1,
  input  logic [TW-1:0]     cfg_setup_cyc,
  input  logic [TW-1:0]     cfg_hold_cyc,
  input  logic [IDLE_W-1:0] cfg_idle_cyc,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n
);

  logic start;
  dly_t setup_m1_now, hi_m1_q, lo_m1_q, hold_m1_q, idle_m1_q;
  logic ev_rise, ev_fall, ev_release;

  assign start = in_valid && in_ready;

  spi_ct_cfg #(.TW(TW), .IDLE_W(IDLE_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (start),
    .sck_hi_m1    (cfg_sck_hi_m1),
    .sck_lo_m1    (cfg_sck_lo_m1),
    .setup_cyc    (cfg_setup_cyc),
    .hold_cyc     (cfg_hold_cyc),
    .idle_cyc     (cfg_idle_cyc),
    .setup_m1_now (setup_m1_now),
    .hi_m1_q      (hi_m1_q),
    .lo_m1_q      (lo_m1_q),
    .hold_m1_q    (hold_m1_q),
    .idle_m1_q    (idle_m1_q)
  );

  spi_ct_seq #(.DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .setup_m1_now (setup_m1_now),
    .hi_m1        (hi_m1_q),
    .lo_m1        (lo_m1_q),
    .hold_m1      (hold_m1_q),
    .idle_m1      (idle_m1_q),
    .ready        (in_ready),
    .cs_n         (spi_cs_n),
    .sck          (spi_sck),
    .ev_rise      (ev_rise),
    .ev_fall      (ev_fall),
    .ev_release   (ev_release)
  );

  spi_ct_shift #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (start),
    .tx_word    (in_data),
    .ev_rise    (ev_rise),
    .ev_fall    (ev_fall),
    .ev_release (ev_release),
    .miso       (spi_miso),
    .mosi       (spi_mosi),
    .rx_data    (rx_data),
    .done       (rx_done)
  );

endmodule

// File: rtl/spi_ct_checker.sv
module spi_ct_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic ready,
  input logic done,
  input logic ev_rise,
  input logic ev_fall,
  input logic ev_release
);

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R6

  AST_READY_LOW_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ready); // R5

  AST_RISE_DRIVES_SCK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> (sck && !cs_n)); // R1

  AST_FALL_KEEPS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> (!sck && !cs_n)); // R1

  AST_RELEASE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_release |=> (cs_n && done)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_CS_RISE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done); // R7

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R6

endmodule

bind spi_cs_timed_master spi_ct_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (spi_cs_n),
  .sck        (spi_sck),
  .mosi       (spi_mosi),
  .ready      (in_ready),
  .done       (rx_done),
  .ev_rise    (ev_rise),
  .ev_fall    (ev_fall),
  .ev_release (ev_release)
);

// File: tb/tb_spi_cs_timed_master.sv
module tb_spi_cs_timed_master;

  localparam int DW = 8;
  localparam int NT = 245;
  localparam int WD = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_hi = '0, cfg_lo = '0, cfg_su = '0, cfg_ho = '0;
  logic [7:0]  cfg_id = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] rx_data;
  logic        rx_done, spi_sck, spi_mosi, spi_cs_n;
  logic        spi_miso = 1'b0;

  always #10 clk = ~clk;

  spi_cs_timed_master #(.DATA_W(DW), .WIDE_TIMING(1)) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_sck_hi_m1(cfg_hi), .cfg_sck_lo_m1(cfg_lo),
    .cfg_setup_cyc(cfg_su), .cfg_hold_cyc(cfg_ho), .cfg_idle_cyc(cfg_id),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rx_data(rx_data), .rx_done(rx_done),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  int checks = 0, fails = 0;
  int a_hi[NT], a_lo[NT], a_su[NT], a_ho[NT], a_id[NT];
  bit all_done = 1'b0;

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int eff(int req, int hi, int lo);
    return (req == 0) ? (hi + lo + 2) : req;
  endfunction

  function automatic logic [DW-1:0] tx_of(int n);
    return DW'((n * 37 + 11) & 255);
  endfunction

  function automatic logic [DW-1:0] sl_of(int n);
    return DW'(((n * 91) ^ 8'h5A) & 255);
  endfunction

  // Port-level monitor and bench-side slave.
  bit          mon_en = 1'b0, in_x = 1'b0, gap_on = 1'b0, chk_done_low = 1'b0, first_low = 1'b0;
  logic        last_sck = 1'b0;
  logic [DW-1:0] mosi_word = '0, sword = '0;
  int          cur = 0, started = 0, finished = 0, run_len = 0, highs = 0, gap_len = 0, bitpos = 0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (chk_done_low) begin
        chk(rx_done == 1'b0, "R7 pulse width", rx_done, 0);
        chk_done_low = 1'b0;
      end
      if (!in_x) begin
        if (!spi_cs_n) begin
          if (gap_on)
            chk(gap_len == eff(a_id[cur], a_hi[cur], a_lo[cur]), "R5 idle gap",
                gap_len, eff(a_id[cur], a_hi[cur], a_lo[cur]));
          chk(in_ready == 1'b0, "R5 ready while selected", in_ready, 0);
          gap_on = 1'b0;
          cur = started;
          started++;
          in_x = 1'b1;
          run_len = 1;
          last_sck = spi_sck;
          highs = 0;
          first_low = 1'b1;
          mosi_word = '0;
          sword = sl_of(cur);
          spi_miso = sword[DW-1];
          bitpos = DW - 2;
        end else if (gap_on) begin
          gap_len++;
        end
      end else if (!spi_cs_n) begin
        if (spi_sck != last_sck) begin
          if (last_sck) begin
            chk(run_len == a_hi[cur] + 1,
                (a_hi[cur] > 255) ? "R9 wide high phase" :
                ((a_hi[cur] == 0 && a_lo[cur] == 0) ? "R2 fastest high" : "R1 high phase"),
                run_len, a_hi[cur] + 1);
            if (bitpos >= 0) begin
              spi_miso = sword[bitpos];
              bitpos--;
            end
          end else begin
            if (first_low)
              chk(run_len == eff(a_su[cur], a_hi[cur], a_lo[cur]), "R3 setup",
                  run_len, eff(a_su[cur], a_hi[cur], a_lo[cur]));
            else
              chk(run_len == a_lo[cur] + 1,
                  (a_hi[cur] == 0 && a_lo[cur] == 0) ? "R2 fastest low" : "R1 low phase",
                  run_len, a_lo[cur] + 1);
            first_low = 1'b0;
            highs++;
            mosi_word = {mosi_word[DW-2:0], spi_mosi};
          end
          run_len = 1;
          last_sck = spi_sck;
        end else begin
          run_len++;
        end
      end else begin
        chk(last_sck == 1'b0 && run_len == eff(a_ho[cur], a_hi[cur], a_lo[cur]),
            "R4 R8 hold", run_len, eff(a_ho[cur], a_hi[cur], a_lo[cur]));
        chk(highs == DW, "R11 edge count", highs, DW);
        chk(mosi_word == tx_of(cur), "R6 mosi word", mosi_word, tx_of(cur));
        chk(rx_done == 1'b1, "R7 done at release", rx_done, 1);
        chk(rx_data == sword, "R6 R7 received word", rx_data, sword);
        chk(spi_sck == 1'b0, "R6 sck idle low", spi_sck, 0);
        chk_done_low = 1'b1;
        in_x = 1'b0;
        gap_on = 1'b1;
        gap_len = 1;
        finished++;
      end
    end
  end

  initial begin
    for (int n = 0; n < NT; n++) begin
      a_hi[n] = n % 3;
      a_lo[n] = ((n / 3) % 3 == 2) ? 3 : (n / 3) % 3;
      a_su[n] = (n / 9) % 3;
      a_ho[n] = ((n / 27) % 3 == 2) ? 3 : (n / 27) % 3;
      a_id[n] = (n / 81) % 3;
    end
    a_hi[243] = 300; a_lo[243] = 2;   a_su[243] = 0; a_ho[243] = 0;   a_id[243] = 200;
    a_hi[244] = 1;   a_lo[244] = 260; a_su[244] = 5; a_ho[244] = 270; a_id[244] = 0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(spi_cs_n == 1'b1, "R10 cs after reset", spi_cs_n, 1);
    chk(spi_sck == 1'b0, "R10 sck after reset", spi_sck, 0);
    chk(rx_done == 1'b0, "R10 done after reset", rx_done, 0);
    chk(in_ready == 1'b1, "R10 ready after reset", in_ready, 1);
    mon_en = 1'b1;

    for (int n = 0; n < NT; n++) begin
      cfg_hi = 16'(a_hi[n]);
      cfg_lo = 16'(a_lo[n]);
      cfg_su = 16'(a_su[n]);
      cfg_ho = 16'(a_ho[n]);
      cfg_id = 8'(a_id[n]);
      in_data = tx_of(n);
      in_valid = 1'b1;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    while (finished < NT) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(finished == NT, "R11 transfer count", finished, NT);
    all_done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!all_done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R11 actual=%0d expected=%0d", finished, NT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule